// File: doc/BRIEF.md
# Segment Address Extension and Protection

This block turns a 32-bit logical address into a 36-bit physical address and checks whether the access is allowed. Each requesting master carries a privilege ID. That ID selects a private set of eight programmable segments. A segment has two registers: a window register, which gives the match base and the size, and a remap register, which gives the replacement page and the read, write and execute enables. Segments may overlap. When several match, the highest-numbered one wins.

Requests arrive on a valid/ready stream. The match, the remap and the permission check are combinational. One output register stage follows them, and responses leave on a second valid/ready stream. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high whenever the output stage is empty or its response is being taken in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response is held unchanged and no new request is accepted. A plain write port loads the segment registers.

Top module: `segxlat_top`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and every segment is disabled, so any request misses.
- R2: A window register keeps the base in bits [31:12] and a size code in bits [4:0]. A code c from 11 to 31 covers 2^(c+1) bytes starting at the base, with the low c+1 bits of the base ignored. Codes 0 to 10 disable the segment.
- R3: On a hit, the physical address takes bits [35:c+1] from the remap page and bits [c:0] from the logical address. The remap register keeps page bits [35:12] in its bits [31:8].
- R4: When several segments of the same privilege ID match, the highest-numbered segment supplies the address and the permissions.
- R5: Segments programmed for one privilege ID have no effect on the requests of any other privilege ID.
- R6: The remap register bit 0 enables reads, bit 1 enables writes and bit 2 enables fetches. A request with `req_write`=1 needs the write enable. Otherwise, `req_fetch`=1 needs the execute enable. Otherwise, the request needs the read enable. A denied hit reports hit=1, fault=1 and the translated address.
- R7: A miss reports hit=0, fault=1 and address 0.
- R8: The response appears one cycle after acceptance. `req_ready` equals `!rsp_valid || rsp_ready`. A response that is not taken stays unchanged.
- R9: A register write (`cfg_we`, with `cfg_remap` 0 for the window register or 1 for the remap register) takes effect after its clock edge. A request accepted at that same edge still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_priv | input | 4 | Privilege ID whose segment is written |
| cfg_seg | input | 3 | Segment index written |
| cfg_remap | input | 1 | 0 selects the window register, 1 selects the remap register |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_addr | input | 32 | Logical address |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch (ignored when writing) |
| req_priv | input | 4 | Privilege ID of the requester |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 36 | Physical address |
| rsp_hit | output | 1 | Some segment matched |
| rsp_fault | output | 1 | Miss or denied access |

## Verification
Every result is due exactly one clock edge after the request is accepted. A register write first affects requests accepted at the following edge. The bench keeps a behavioural model that uses these same rules at each rising edge. It computes the expected response before it applies any write in that cycle. At the falling edge of every cycle, the model's `rsp_valid`, `req_ready` and response fields are compared with the design's outputs. Randomly stalled `rsp_ready` phases check that held responses do not change and that nothing is accepted while the output is blocked.

// File: rtl/segxlat_pkg.sv
package segxlat_pkg;
  localparam int LOG_AW    = 32;
  localparam int PHYS_AW   = 36;
  localparam int PAGE_BITS = 12;
  localparam int CODE_W    = 5;
  localparam int MIN_CODE  = PAGE_BITS - 1;
  localparam int BASE_W    = LOG_AW - PAGE_BITS;
  localparam int PAGE_W    = PHYS_AW - PAGE_BITS;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [CODE_W-1:0] code;
  } win_t;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic              x_en;
    logic              w_en;
    logic              r_en;
  } remap_t;

  // Mask of the offset bits kept from the logical address for a size code.
  function automatic logic [LOG_AW-1:0] span_mask(input logic [CODE_W-1:0] code);
    logic [CODE_W:0] sh;
    sh = {1'b0, code} + 1'b1;
    return ~({LOG_AW{1'b1}} << sh);
  endfunction
endpackage

// File: rtl/segxlat_regs.sv
module segxlat_regs
  import segxlat_pkg::*;
#(
  parameter int NUM_PRIV = 16,
  parameter int NUM_SEG  = 8,
  localparam int PRIV_W  = $clog2(NUM_PRIV),
  localparam int SEG_W   = $clog2(NUM_SEG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [PRIV_W-1:0]         wr_priv,
  input  logic [SEG_W-1:0]          wr_seg,
  input  logic                      wr_remap,
  input  logic [LOG_AW-1:0]         wr_data,
  input  logic [PRIV_W-1:0]         rd_priv,
  output win_t   [NUM_SEG-1:0]      rd_win,
  output remap_t [NUM_SEG-1:0]      rd_remap
);
  win_t   [NUM_SEG-1:0] win_q   [NUM_PRIV];
  remap_t [NUM_SEG-1:0] remap_q [NUM_PRIV];

  win_t   win_new;
  remap_t remap_new;

  always_comb begin
    win_new.base    = wr_data[LOG_AW-1:PAGE_BITS];
    win_new.code    = wr_data[CODE_W-1:0];
    remap_new.page  = wr_data[LOG_AW-1:LOG_AW-PAGE_W];
    remap_new.x_en  = wr_data[2];
    remap_new.w_en  = wr_data[1];
    remap_new.r_en  = wr_data[0];
  end

  for (genvar p = 0; p < NUM_PRIV; p++) begin : g_priv
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      logic hit_w;
      assign hit_w = wr_en && (wr_priv == PRIV_W'(p)) && (wr_seg == SEG_W'(s));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          win_q[p][s]   <= '0;
          remap_q[p][s] <= '0;
        end else if (hit_w) begin
          if (wr_remap) remap_q[p][s] <= remap_new;
          else          win_q[p][s]   <= win_new;
        end
      end
    end
  end

  assign rd_win   = win_q[rd_priv];
  assign rd_remap = remap_q[rd_priv];
endmodule

// File: rtl/segxlat_match.sv
module segxlat_match
  import segxlat_pkg::*;
(
  input  logic [LOG_AW-1:0]  addr,
  input  win_t               win,
  input  remap_t             remap,
  output logic               hit,
  output logic [PHYS_AW-1:0] phys
);
  logic [LOG_AW-1:0]  keep;
  logic [LOG_AW-1:0]  base_full;
  logic [PHYS_AW-1:0] page_full;
  logic               enabled;

  always_comb begin
    keep      = span_mask(win.code);
    base_full = {win.base, {PAGE_BITS{1'b0}}};
    page_full = {remap.page, {PAGE_BITS{1'b0}}};
    enabled   = (win.code >= CODE_W'(MIN_CODE));
    hit       = enabled && (((addr ^ base_full) & ~keep) == '0);
    phys      = (page_full & ~{{(PHYS_AW-LOG_AW){1'b0}}, keep})
              | {{(PHYS_AW-LOG_AW){1'b0}}, addr & keep};
  end
endmodule

// File: rtl/segxlat_pick.sv
module segxlat_pick
  import segxlat_pkg::*;
#(
  parameter int NUM_SEG = 8
) (
  input  logic   [NUM_SEG-1:0]                seg_hit,
  input  logic   [NUM_SEG-1:0][PHYS_AW-1:0]   seg_phys,
  input  remap_t [NUM_SEG-1:0]                seg_remap,
  output logic                                any_hit,
  output logic   [PHYS_AW-1:0]                win_phys,
  output logic                                r_ok,
  output logic                                w_ok,
  output logic                                x_ok
);
  always_comb begin
    any_hit  = 1'b0;
    win_phys = '0;
    r_ok     = 1'b0;
    w_ok     = 1'b0;
    x_ok     = 1'b0;
    // Later (higher) indices override earlier ones.
    for (int i = 0; i < NUM_SEG; i++) begin
      if (seg_hit[i]) begin
        any_hit  = 1'b1;
        win_phys = seg_phys[i];
        r_ok     = seg_remap[i].r_en;
        w_ok     = seg_remap[i].w_en;
        x_ok     = seg_remap[i].x_en;
      end
    end
  end
endmodule

// File: rtl/segxlat_top.sv
module segxlat_top
  import segxlat_pkg::*;
#(
  parameter int NUM_PRIV = 16,
  parameter int NUM_SEG  = 8,
  localparam int PRIV_W  = $clog2(NUM_PRIV),
  localparam int SEG_W   = $clog2(NUM_SEG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [PRIV_W-1:0]  cfg_priv,
  input  logic [SEG_W-1:0]   cfg_seg,
  input  logic               cfg_remap,
  input  logic [LOG_AW-1:0]  cfg_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LOG_AW-1:0]  req_addr,
  input  logic               req_write,
  input  logic               req_fetch,
  input  logic [PRIV_W-1:0]  req_priv,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PHYS_AW-1:0] rsp_addr,
  output logic               rsp_hit,
  output logic               rsp_fault
);
  win_t   [NUM_SEG-1:0]              seg_win;
  remap_t [NUM_SEG-1:0]              seg_remap;
  logic   [NUM_SEG-1:0]              seg_hit;
  logic   [NUM_SEG-1:0][PHYS_AW-1:0] seg_phys;

  logic               any_hit;
  logic [PHYS_AW-1:0] win_phys;
  logic               r_ok, w_ok, x_ok;
  logic               allowed;
  logic               accept;

  segxlat_regs #(.NUM_PRIV(NUM_PRIV), .NUM_SEG(NUM_SEG)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_priv  (cfg_priv),
    .wr_seg   (cfg_seg),
    .wr_remap (cfg_remap),
    .wr_data  (cfg_wdata),
    .rd_priv  (req_priv),
    .rd_win   (seg_win),
    .rd_remap (seg_remap)
  );

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_match
    segxlat_match match_i (
      .addr  (req_addr),
      .win   (seg_win[s]),
      .remap (seg_remap[s]),
      .hit   (seg_hit[s]),
      .phys  (seg_phys[s])
    );
  end

  segxlat_pick #(.NUM_SEG(NUM_SEG)) pick_i (
    .seg_hit   (seg_hit),
    .seg_phys  (seg_phys),
    .seg_remap (seg_remap),
    .any_hit   (any_hit),
    .win_phys  (win_phys),
    .r_ok      (r_ok),
    .w_ok      (w_ok),
    .x_ok      (x_ok)
  );

  always_comb begin
    if (req_write)      allowed = w_ok;
    else if (req_fetch) allowed = x_ok;
    else                allowed = r_ok;
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_addr  <= any_hit ? win_phys : '0;
      rsp_hit   <= any_hit;
      rsp_fault <= !any_hit || !allowed;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/segxlat_checker.sv
module segxlat_checker
  import segxlat_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [LOG_AW-1:0]  req_addr,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [PHYS_AW-1:0] rsp_addr,
  input logic               rsp_hit,
  input logic               rsp_fault
);
  logic [PAGE_BITS-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      lo_q <= '0;
    else if (req_valid && req_ready) lo_q <= req_addr[PAGE_BITS-1:0];
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_hit) && $stable(rsp_fault));

  a_r8_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  a_r7_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_fault && (rsp_addr == '0));

  a_r3_offset: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> rsp_addr[PAGE_BITS-1:0] == lo_q);
endmodule

bind segxlat_top segxlat_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_addr  (rsp_addr),
  .rsp_hit   (rsp_hit),
  .rsp_fault (rsp_fault)
);

// File: tb/segxlat_top_tb.sv
module segxlat_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_priv = '0;
  logic [2:0]  cfg_seg = '0;
  logic        cfg_remap = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_fetch = 1'b0;
  logic [3:0]  req_priv = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [35:0] rsp_addr;
  logic        rsp_hit;
  logic        rsp_fault;

  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R1";
  bit    bp_mode = 1'b0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  segxlat_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_seg(cfg_seg),
    .cfg_remap(cfg_remap), .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_fetch(req_fetch), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault)
  );

  // Behavioural model state
  bit [19:0] m_base [16][8];
  bit [4:0]  m_code [16][8];
  bit [23:0] m_page [16][8];
  bit [2:0]  m_perm [16][8];
  bit        m_valid = 0;
  bit [35:0] m_addr;
  bit        m_hit, m_fault;
  string     m_tag = "R1";

  function automatic void ref_xlat(input int pv, input bit [31:0] a, input bit wr, input bit fe,
                                   output bit [35:0] pa, output bit hit, output bit fault);
    int sel = -1;
    longint span;
    for (int s = 0; s < 8; s++) begin
      if (m_code[pv][s] >= 11) begin
        span = 64'd1 << (m_code[pv][s] + 1);
        if ((longint'(a) / span) == ((longint'(m_base[pv][s]) << 12) / span)) sel = s;
      end
    end
    if (sel < 0) begin
      pa = '0; hit = 0; fault = 1;
    end else begin
      longint pg;
      bit need;
      span = 64'd1 << (m_code[pv][sel] + 1);
      pg   = longint'(m_page[pv][sel]) << 12;
      pa   = 36'(pg - (pg % span) + (longint'(a) % span));
      hit  = 1;
      need = wr ? m_perm[pv][sel][1] : (fe ? m_perm[pv][sel][2] : m_perm[pv][sel][0]);
      fault = !need;
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0;
      for (int p = 0; p < 16; p++)
        for (int s = 0; s < 8; s++) begin
          m_base[p][s] = 0; m_code[p][s] = 0; m_page[p][s] = 0; m_perm[p][s] = 0;
        end
    end else begin
      bit rdy;
      rdy = !m_valid || rsp_ready;
      if (req_valid && rdy) begin
        ref_xlat(int'(req_priv), req_addr, req_write, req_fetch, m_addr, m_hit, m_fault);
        m_valid = 1;
        m_tag   = cur_tag;
      end else if (rsp_ready) begin
        m_valid = 0;
      end
      if (cfg_we) begin
        if (cfg_remap) begin
          m_page[cfg_priv][cfg_seg] = cfg_wdata[31:8];
          m_perm[cfg_priv][cfg_seg] = cfg_wdata[2:0];
        end else begin
          m_base[cfg_priv][cfg_seg] = cfg_wdata[31:12];
          m_code[cfg_priv][cfg_seg] = cfg_wdata[4:0];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (req_ready !== (!m_valid || rsp_ready) || rsp_valid !== m_valid) begin
        errors++;
        $display("FAIL R8: ready=%0b valid=%0b expected ready=%0b valid=%0b",
                 req_ready, rsp_valid, (!m_valid || rsp_ready), m_valid);
      end
      if (m_valid) begin
        checks++;
        if (rsp_addr !== m_addr || rsp_hit !== m_hit || rsp_fault !== m_fault) begin
          errors++;
          $display("FAIL %s: addr=%h hit=%0b fault=%0b expected addr=%h hit=%0b fault=%0b",
                   m_tag, rsp_addr, rsp_hit, rsp_fault, m_addr, m_hit, m_fault);
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    rsp_ready = bp_mode ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  task automatic wcfg(input int pv, input int sg, input bit rm, input bit [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_priv = 4'(pv); cfg_seg = 3'(sg); cfg_remap = rm; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic send(input int pv, input bit [31:0] a, input bit wr, input bit fe, input string tag);
    @(posedge clk); #1;
    cur_tag = tag;
    req_valid = 1; req_priv = 4'(pv); req_addr = a; req_write = wr; req_fetch = fe;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1: rsp_valid=%0b req_ready=%0b expected 0 1", rsp_valid, req_ready);
    end
    rst_n = 1;

    send(2, 32'h8000_0123, 0, 0, "R1");                 // nothing programmed: miss
    // priv 2 seg 0: 4 KB at 0x8000_0000 -> page 0x9_1234_5, read+write
    wcfg(2, 0, 0, 32'h8000_0000 | 32'd11);
    wcfg(2, 0, 1, (32'h912345 << 8) | 32'b011);
    send(2, 32'h8000_0ABC, 0, 0, "R3");
    send(2, 32'h8000_1ABC, 0, 0, "R2");                 // just past 4 KB
    wcfg(2, 2, 0, 32'h7000_0000 | 32'd10);               // code 10: disabled
    wcfg(2, 2, 1, (32'h000100 << 8) | 32'b111);
    send(2, 32'h7000_0010, 0, 0, "R2");
    // seg 1: 1 MB at 0x1000_0000 (base low bits set, ignored) -> 0xF_0000_0000
    wcfg(2, 1, 0, 32'h1003_4000 | 32'd19);
    wcfg(2, 1, 1, (32'hF00000 << 8) | 32'b111);
    send(2, 32'h100A_BCDE, 0, 0, "R3");
    // seg 5 overlaps: 64 KB at 0x1000_0000, read only, page 0x2_0000_0
    wcfg(2, 5, 0, 32'h1000_0000 | 32'd15);
    wcfg(2, 5, 1, (32'h200000 << 8) | 32'b001);
    send(2, 32'h1000_4444, 0, 0, "R4");
    send(2, 32'h1002_4444, 0, 0, "R4");                 // outside seg 5, in seg 1
    send(2, 32'h1000_4444, 1, 0, "R6");                 // write denied
    send(2, 32'h1000_4444, 0, 1, "R6");                 // fetch denied
    send(2, 32'h1002_0000, 1, 1, "R6");                 // write allowed in seg 1
    send(2, 32'h8000_0004, 0, 1, "R6");                 // fetch denied in seg 0
    send(3, 32'h1000_4444, 0, 0, "R5");
    send(3, 32'h8000_0ABC, 0, 0, "R7");
    // priv 3 seg 7: whole space (code 31), execute only
    wcfg(3, 7, 0, 32'd31);
    wcfg(3, 7, 1, (32'hABCDEF << 8) | 32'b100);
    send(3, 32'hDEAD_BEEF, 0, 1, "R2");
    send(2, 32'hDEAD_BEEF, 0, 1, "R5");
    // Same-edge write and request: request sees the old window
    @(posedge clk); #1;
    cur_tag = "R9";
    cfg_we = 1; cfg_priv = 2; cfg_seg = 0; cfg_remap = 0; cfg_wdata = 32'h4000_0000 | 32'd11;
    req_valid = 1; req_priv = 2; req_addr = 32'h8000_0010; req_write = 0; req_fetch = 0;
    @(posedge clk); #1;
    cfg_we = 0; req_valid = 0;
    send(2, 32'h8000_0010, 0, 0, "R9");
    send(2, 32'h4000_0FF0, 0, 0, "R9");
    // Back-pressure with random traffic
    bp_mode = 1;
    for (int i = 0; i < 200; i++) begin
      int pv;
      bit [31:0] a;
      pv = 2 + int'($urandom_range(0, 1));
      case ($urandom_range(0, 3))
        0: a = 32'h1000_0000 | 32'($urandom_range(0, 32'h3_FFFF));
        1: a = 32'h4000_0000 | 32'($urandom_range(0, 32'h1FFF));
        2: a = $urandom;
        default: a = 32'h100F_0000 | 32'($urandom_range(0, 32'h2_FFFF));
      endcase
      send(pv, a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R8");
    end
    bp_mode = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule